// File: doc/BRIEF.md
# Big-Endian Byte-Lane Data Memory

This block is the data store of a 32-bit load/store pipeline. Each access supplies a 32-bit base register value and a 16-bit two's-complement displacement. The block adds them to form a byte address and serves one of five operations: word read, word write, byte read with sign fill, byte read with zero fill, and byte write. Storage is an array of 32-bit words, and each byte address picks one lane of a word.

Lanes are numbered big-endian. The byte at the word's own address is the most significant byte, and the byte three addresses above it is the least significant. Reads are combinational from the current address. Writes land on the rising clock edge. A byte write merges a single lane into the stored word. A word access whose address is not a multiple of four raises a flag, and a write with that flag raised is dropped.

Top module: `be_data_mem`

## Requirements
- R1: While `rst_n` is low, every stored word is cleared to zero, and reads after reset return zero at every address.
- R2: The effective address is `base_addr` plus `offset` sign-extended to 32 bits, modulo 2^32. Address bits [7:2] (with the default depth of 64 words) select the word, and higher bits are ignored, so addresses alias.
- R3: `misalign` is 1 exactly when `byte_mode` is 0 and address bits [1:0] are not 00. A byte access never raises it.
- R4: Lane order is big-endian. The byte at address bits [1:0] = k sits in word bits [31-8k:24-8k], so bytes FA,5D,1B,68 at X..X+3 form the word 0xFA5D1B68.
- R5: A byte read with `byte_mode`=1 and `zero_ext`=0 returns the addressed byte in bits [7:0], and every bit of [31:8] equals bit 7.
- R6: A byte read with `byte_mode`=1 and `zero_ext`=1 returns the addressed byte in bits [7:0] and zero in bits [31:8].
- R7: A byte write (`byte_mode`=1, `wr_en`=1) stores `wr_data[7:0]` into the addressed lane only. The other three lanes keep their contents.
- R8: An aligned word write stores `wr_data` at the rising edge. During the write cycle `rd_data` still shows the old word, and from the next cycle it shows the new word.
- R9: A word write with `misalign`=1 changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, clears storage |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| byte_mode | input | 1 | 1 = byte access, 0 = word access |
| zero_ext | input | 1 | For byte reads: 1 = zero fill, 0 = sign fill |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | 32 | Store data; a byte write uses bits [7:0] |
| rd_data | output | 32 | Combinational read result |
| misalign | output | 1 | Word access at an address that is not a multiple of four |

## Verification
Reading and writing share one address. In the cycle a write is issued, `rd_data` must still show the old contents, and the bench checks this on the write cycle itself, then re-reads the same address on the next cycle to see the new value. The misalign flag and a write request also coincide: a word write is driven at an odd address, the flag is judged in that cycle, and the aligned word is read back next cycle to confirm that no lane changed.

// File: rtl/be_dmem_pkg.sv
`timescale 1ns/1ps
package be_dmem_pkg;
   localparam int unsigned LANE_W     = 8;
   localparam int unsigned WORD_LANES = 4;
   localparam int unsigned WORD_W     = LANE_W * WORD_LANES;

   // Big-endian: lane 0 is the most significant byte of the word.
   function automatic logic [4:0] lane_shift(input logic [1:0] lane);
      return {2'd3 - lane, 3'b000};
   endfunction
endpackage

// File: rtl/be_dmem_addr.sv
`timescale 1ns/1ps
module be_dmem_addr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFFS_W = 16,
   parameter int unsigned IDX_W  = 6
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [OFFS_W-1:0] offset,
   input  logic              byte_mode,
   output logic [IDX_W-1:0]  word_idx,
   output logic [1:0]        lane,
   output logic              misalign
);
   localparam int unsigned EXT_W = ADDR_W - OFFS_W;

   logic [ADDR_W-1:0]        eff_addr;
   logic [ADDR_W-IDX_W-3:0]  eff_hi_unused;

   assign eff_addr      = base_addr + {{EXT_W{offset[OFFS_W-1]}}, offset};
   assign word_idx      = eff_addr[IDX_W+1:2];
   assign lane          = eff_addr[1:0];
   assign eff_hi_unused = eff_addr[ADDR_W-1:IDX_W+2];
   assign misalign      = ~byte_mode & (|eff_addr[1:0]);
endmodule

// File: rtl/be_dmem_read.sv
`timescale 1ns/1ps
module be_dmem_read
   import be_dmem_pkg::*;
(
   input  logic [WORD_W-1:0] word_in,
   input  logic [1:0]        lane,
   input  logic              byte_mode,
   input  logic              zero_ext,
   output logic [WORD_W-1:0] rd_out
);
   logic [LANE_W-1:0]        sel_byte;
   logic [WORD_W-LANE_W-1:0] fill;

   always_comb begin
      sel_byte = LANE_W'(word_in >> lane_shift(lane));
      fill     = zero_ext ? '0 : {(WORD_W-LANE_W){sel_byte[LANE_W-1]}};
      rd_out   = byte_mode ? {fill, sel_byte} : word_in;
   end
endmodule

// File: rtl/be_dmem_merge.sv
`timescale 1ns/1ps
module be_dmem_merge
   import be_dmem_pkg::*;
(
   input  logic [WORD_W-1:0] old_word,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [1:0]        lane,
   input  logic              byte_mode,
   output logic [WORD_W-1:0] new_word
);
   logic [WORD_W-1:0] keep_mask;
   logic [WORD_W-1:0] ins_data;

   always_comb begin
      if (byte_mode) begin
         keep_mask = ~({{(WORD_W-LANE_W){1'b0}}, {LANE_W{1'b1}}} << lane_shift(lane));
         ins_data  = {{(WORD_W-LANE_W){1'b0}}, wr_data[LANE_W-1:0]} << lane_shift(lane);
      end else begin
         keep_mask = '0;
         ins_data  = wr_data;
      end
      new_word = (old_word & keep_mask) | ins_data;
   end
endmodule

// File: rtl/be_data_mem.sv
`timescale 1ns/1ps
module be_data_mem
   import be_dmem_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned OFFS_W      = 16,
   parameter int unsigned DEPTH_WORDS = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [OFFS_W-1:0] offset,
   input  logic              byte_mode,
   input  logic              zero_ext,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data,
   output logic              misalign
);
   localparam int unsigned IDX_W = $clog2(DEPTH_WORDS);

   if (DEPTH_WORDS < 2 || (DEPTH_WORDS & (DEPTH_WORDS - 1)) != 0) begin : g_bad_depth
      $error("be_data_mem: DEPTH_WORDS must be a power of two of at least 2");
   end
   if (OFFS_W < 1 || OFFS_W >= ADDR_W) begin : g_bad_offs
      $error("be_data_mem: OFFS_W must be between 1 and ADDR_W-1");
   end
   if (IDX_W + 2 >= ADDR_W) begin : g_bad_span
      $error("be_data_mem: storage span exceeds the address width");
   end

   logic [IDX_W-1:0]  word_idx;
   logic [1:0]        lane;
   logic              wr_fire;
   logic [WORD_W-1:0] cur_word;
   logic [WORD_W-1:0] merged_word;
   logic [WORD_W-1:0] mem_q [DEPTH_WORDS];

   be_dmem_addr #(
      .ADDR_W (ADDR_W),
      .OFFS_W (OFFS_W),
      .IDX_W  (IDX_W)
   ) i_addr (
      .base_addr (base_addr),
      .offset    (offset),
      .byte_mode (byte_mode),
      .word_idx  (word_idx),
      .lane      (lane),
      .misalign  (misalign)
   );

   assign cur_word = mem_q[word_idx];
   assign wr_fire  = wr_en & ~misalign;

   be_dmem_merge i_merge (
      .old_word  (cur_word),
      .wr_data   (wr_data),
      .lane      (lane),
      .byte_mode (byte_mode),
      .new_word  (merged_word)
   );

   for (genvar w = 0; w < DEPTH_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_q[w] <= '0;
         end else if (wr_fire && word_idx == IDX_W'(w)) begin
            mem_q[w] <= merged_word;
         end
      end
   end

   be_dmem_read i_read (
      .word_in   (cur_word),
      .lane      (lane),
      .byte_mode (byte_mode),
      .zero_ext  (zero_ext),
      .rd_out    (rd_data)
   );
endmodule

// File: rtl/be_data_mem_chk.sv
`timescale 1ns/1ps
module be_data_mem_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] base_addr,
   input logic [15:0] offset,
   input logic        byte_mode,
   input logic        zero_ext,
   input logic        wr_en,
   input logic [31:0] wr_data,
   input logic [31:0] rd_data,
   input logic        misalign
);
   logic [1:0] chk_lane;
   assign chk_lane = base_addr[1:0] + offset[1:0];

   p_align_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      misalign == (!byte_mode && chk_lane != 2'b00));

   p_sign_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_mode && !zero_ext) |-> (rd_data[31:8] == {24{rd_data[7]}}));

   p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_mode && zero_ext) |-> (rd_data[31:8] == 24'd0));

   p_word_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !byte_mode && !misalign) ##1
      ($stable(base_addr) && $stable(offset) && !byte_mode)
      |-> (rd_data == $past(wr_data)));

   p_misalign_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && misalign) ##1
      ($stable(base_addr) && $stable(offset) && !byte_mode)
      |-> $stable(rd_data));
endmodule

bind be_data_mem be_data_mem_chk i_chk (.*);

// File: tb/test_be_data_mem.sv
`timescale 1ns/1ps
module test_be_data_mem;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] base_addr = '0;
   logic [15:0] offset = '0;
   logic        byte_mode = 1'b0;
   logic        zero_ext = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        misalign;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] exp_d;
      logic        exp_m;
      bit          chk_d;
      string       tag;
   } item_t;

   item_t       sb_q[$];
   logic [7:0]  ref_mem [256];

   always #2 clk = ~clk;

   be_data_mem i_be_data_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_addr (base_addr),
      .offset    (offset),
      .byte_mode (byte_mode),
      .zero_ext  (zero_ext),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .misalign  (misalign)
   );

   // Driver: one access per cycle, expectation pushed from the reference model.
   task automatic access(input logic [31:0] b, input logic [15:0] o, input logic bm,
                         input logic ze, input logic we, input logic [31:0] wd,
                         input bit chk_d, input string tag);
      logic [31:0] ea;
      logic [7:0]  wa;
      logic [7:0]  by;
      item_t       it;
      @(posedge clk);
      #1;
      base_addr = b; offset = o; byte_mode = bm; zero_ext = ze; wr_en = we; wr_data = wd;
      ea = b + {{16{o[15]}}, o};
      wa = {ea[7:2], 2'b00};
      by = ref_mem[ea[7:0]];
      it.exp_m = !bm && (ea[1:0] != 2'b00);
      if (bm) it.exp_d = ze ? {24'd0, by} : {{24{by[7]}}, by};
      else    it.exp_d = {ref_mem[wa], ref_mem[wa+8'd1], ref_mem[wa+8'd2], ref_mem[wa+8'd3]};
      it.chk_d = chk_d;
      it.tag   = tag;
      sb_q.push_back(it);
      if (we && !it.exp_m) begin
         if (bm) ref_mem[ea[7:0]] = wd[7:0];
         else begin
            ref_mem[wa]      = wd[31:24];
            ref_mem[wa+8'd1] = wd[23:16];
            ref_mem[wa+8'd2] = wd[15:8];
            ref_mem[wa+8'd3] = wd[7:0];
         end
      end
   endtask

   task automatic rd(input logic [31:0] b, input logic [15:0] o, input logic bm,
                     input logic ze, input string tag);
      access(b, o, bm, ze, 1'b0, 32'd0, 1'b1, tag);
   endtask

   // Monitor: compares at the falling edge, after combinational reads settle.
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (misalign !== it.exp_m) begin
               errors++;
               $display("FAIL %s misalign actual %0b expected %0b", it.tag, misalign, it.exp_m);
            end
            if (it.chk_d) begin
               checks++;
               if (rd_data !== it.exp_d) begin
                  errors++;
                  $display("FAIL %s rd_data actual %08h expected %08h", it.tag, rd_data, it.exp_d);
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: cleared after reset
      rd(32'h0000_0000, 16'h0000, 1'b0, 1'b0, "R1");
      rd(32'h0000_0080, 16'h0000, 1'b0, 1'b0, "R1");
      rd(32'h0000_00FC, 16'h0000, 1'b0, 1'b0, "R1");
      rd(32'h0000_0041, 16'h0000, 1'b1, 1'b0, "R1");

      // R8: write cycle shows old word, next cycle the new one
      access(32'h0000_0010, 16'h0000, 1'b0, 1'b0, 1'b1, 32'hFA5D_1B68, 1'b1, "R8");
      rd(32'h0000_0010, 16'h0000, 1'b0, 1'b0, "R8");

      // R4 / R6: big-endian lanes, unsigned bytes FA 5D 1B 68
      rd(32'h0000_0010, 16'h0000, 1'b1, 1'b1, "R4");
      rd(32'h0000_0011, 16'h0000, 1'b1, 1'b1, "R4");
      rd(32'h0000_0012, 16'h0000, 1'b1, 1'b1, "R4");
      rd(32'h0000_0013, 16'h0000, 1'b1, 1'b1, "R6");

      // R5: sign fill
      rd(32'h0000_0010, 16'h0000, 1'b1, 1'b0, "R5");
      rd(32'h0000_0011, 16'h0000, 1'b1, 1'b0, "R5");

      // R2: negative offset, 32-bit wrap, aliasing of high bits
      rd(32'h0000_0020, 16'hFFF0, 1'b0, 1'b0, "R2");
      rd(32'hFFFF_FFF0, 16'h0020, 1'b0, 1'b0, "R2");
      rd(32'h0000_0110, 16'h0000, 1'b0, 1'b0, "R2");

      // R7: byte store merges one lane, R3: byte access never misaligned
      access(32'h0000_0012, 16'h0000, 1'b1, 1'b0, 1'b1, 32'hAAAA_AA99, 1'b1, "R7");
      rd(32'h0000_0010, 16'h0000, 1'b0, 1'b0, "R7");
      access(32'h0000_0017, 16'hFFFC, 1'b1, 1'b0, 1'b1, 32'h0000_0042, 1'b1, "R3");
      rd(32'h0000_0010, 16'h0000, 1'b0, 1'b0, "R7");

      // R9 / R3: misaligned word write dropped
      access(32'h0000_0011, 16'h0000, 1'b0, 1'b0, 1'b1, 32'h1234_5678, 1'b0, "R9");
      rd(32'h0000_0011, 16'h0000, 1'b0, 1'b0, "R9");
      rd(32'h0000_0010, 16'h0000, 1'b0, 1'b0, "R9");
      rd(32'h0000_0020, 16'h0002, 1'b0, 1'b0, "R3");
      access(32'h0000_0013, 16'h0001, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, "R3");
      rd(32'h0000_0014, 16'h0000, 1'b0, 1'b0, "R9");

      // R5 / R6 second pattern
      access(32'h0000_0040, 16'h0000, 1'b0, 1'b0, 1'b1, 32'h80FF_7F01, 1'b1, "R8");
      rd(32'h0000_0040, 16'h0000, 1'b1, 1'b0, "R5");
      rd(32'h0000_0041, 16'h0000, 1'b1, 1'b0, "R5");
      rd(32'h0000_0042, 16'h0000, 1'b1, 1'b0, "R5");
      rd(32'h0000_0043, 16'h0000, 1'b1, 1'b0, "R5");
      rd(32'h0000_0041, 16'h0000, 1'b1, 1'b1, "R6");
      rd(32'h0000_0040, 16'h0000, 1'b1, 1'b1, "R6");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule